// File: doc/BRIEF.md
# Pausable Multi-Step Integer and Fractional Divider

This block divides a dividend by a 16-bit divisor over a fixed run of 19 enabled clock steps. It produces a 16-bit quotient, a 16-bit remainder, a completion flag and a zero-divisor flag. Three mode inputs select the operation. They choose a short (16-bit) or wide (32-bit) dividend, unsigned or two's-complement signed operands, and integer or fractional (1.15 quotient) results.

A start pulse captures the operands while the block is idle. From then on, every clock on which the step-enable input is high advances the calculation by one step. The first step takes operand magnitudes and signs. The next sixteen each settle one quotient bit using a non-restoring shift/add-or-subtract. One step then corrects a negative partial remainder, and the last applies the signs and registers the results. Dropping step-enable at any point holds all partial state, so a host can suspend the division for an interrupt and resume it later without any loss.

Top module: `iter_divider`

## Requirements
- R1: After synchronous reset, `done`, `div_zero`, `quotient` and `remainder` are all zero.
- R2: A `start` pulse seen while idle captures `dividend`, `divisor`, `wide`, `sgn` and `frac`, and clears `done` on that same clock edge.
- R3: `done` rises on the clock edge of the 19th enabled step after the capturing edge, and never earlier. A step is a clock with `step_en` high.
- R4: While `step_en` is low during a division, no progress is made and no partial state changes, so the final results equal those of an uninterrupted run.
- R5: In unsigned integer mode with `wide`=0, `quotient` = `dividend[15:0]` / `divisor` and `remainder` = `dividend[15:0]` mod `divisor`.
- R6: In unsigned integer mode with `wide`=1, the full 32-bit `dividend` is divided. Results are exact whenever the true quotient fits in 16 bits.
- R7: With `sgn`=1, operands are two's complement, the quotient is truncated toward zero and the remainder carries the sign of the dividend. This holds for both dividend widths, whenever the quotient fits in 16 signed bits.
- R8: With `frac`=1, `dividend[15:0]` is scaled by 2^15 before dividing, so that a dividend smaller in magnitude than the divisor yields a 1.15 quotient. `wide` is ignored in this mode, and `sgn` applies as in R7.
- R9: `div_zero` is set on the capturing edge when `divisor` is zero and cleared on the next capture with a nonzero divisor. `done` still follows R3, and the quotient and remainder are unspecified in that case.
- R10: A `start` pulse, or any change on the operand inputs, while a division is in progress is ignored.
- R11: `quotient` and `remainder` change only on the edge that sets `done`, and hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; accepted only while idle |
| step_en | input | 1 | Advance one step on this clock; low suspends |
| dividend | input | 32 | Dividend; only bits 15:0 are used unless `wide`=1 and `frac`=0 |
| divisor | input | 16 | Divisor |
| wide | input | 1 | 1 selects a 32-bit dividend for integer division |
| sgn | input | 1 | 1 selects two's-complement operands |
| frac | input | 1 | 1 selects fractional (1.15) division |
| quotient | output | 16 | Registered quotient |
| remainder | output | 16 | Registered remainder |
| done | output | 1 | High from completion until the next accepted start |
| div_zero | output | 1 | Divisor was zero for the current or last division |

## Verification
The hardest situation to reach is a division frozen at an arbitrary interior step. In particular, the freeze can land right on the correction step or the sign step, with the partial remainder negative at that moment. Step-enable therefore toggles randomly at several duty levels across many signed, wide and fractional operand sets. This scatters the pauses over every one of the 19 steps. A behavioural model counts enabled steps independently and predicts `done` and the results on every clock. Some runs also pulse `start` with altered operands in mid-flight, to confirm that the captured values stay in force.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef struct packed {
    logic wide;
    logic sgn;
    logic frac;
  } div_mode_t;
endpackage

// File: rtl/div_setup.sv
module div_setup
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2*W-1:0] a,
  input  logic [W-1:0]   b,
  input  div_mode_t      mode,
  output logic [W+1:0]   p_init,
  output logic [W-1:0]   n_init,
  output logic [W-1:0]   b_mag,
  output logic           q_neg,
  output logic           r_neg
);
  localparam int DW = 2 * W;

  logic [DW-1:0] a_ext, a_abs, a_mag;
  logic          a_neg, b_neg;

  always_comb begin
    if (mode.wide && !mode.frac) a_ext = a;
    else if (mode.sgn)           a_ext = {{W{a[W-1]}}, a[W-1:0]};
    else                         a_ext = {{W{1'b0}}, a[W-1:0]};
    a_neg  = mode.sgn & a_ext[DW-1];
    b_neg  = mode.sgn & b[W-1];
    a_abs  = a_neg ? (~a_ext + 1'b1) : a_ext;
    // fractional: scale so the quotient lands in 1.(W-1) format
    a_mag  = mode.frac ? (a_abs << (W - 1)) : a_abs;
    b_mag  = b_neg ? (~b + 1'b1) : b;
    p_init = {2'b00, a_mag[DW-1:W]};
    n_init = a_mag[W-1:0];
    q_neg  = a_neg ^ b_neg;
    r_neg  = a_neg;
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 16
) (
  input  logic [W+1:0] p_in,
  input  logic [W-1:0] n_in,
  input  logic [W-1:0] b,
  output logic [W+1:0] p_out,
  output logic [W-1:0] n_out
);
  localparam int PW = W + 2;

  logic [PW-1:0] sh;

  always_comb begin
    sh    = {p_in[PW-2:0], n_in[W-1]};
    // non-restoring: add back when the partial remainder went negative
    p_out = p_in[PW-1] ? (sh + {2'b00, b}) : (sh - {2'b00, b});
    n_out = {n_in[W-2:0], ~p_out[PW-1]};
  end
endmodule

// File: rtl/div_fixup.sv
module div_fixup #(
  parameter int W = 16
) (
  input  logic [W-1:0] q_mag,
  input  logic [W+1:0] p_fin,
  input  logic         q_neg,
  input  logic         r_neg,
  output logic [W-1:0] q_out,
  output logic [W-1:0] r_out
);
  always_comb begin
    q_out = q_neg ? (~q_mag + 1'b1) : q_mag;
    r_out = r_neg ? (~p_fin[W-1:0] + 1'b1) : p_fin[W-1:0];
  end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           step_en,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic           wide,
  input  logic           sgn,
  input  logic           frac,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           done,
  output logic           div_zero
);
  localparam int DW    = 2 * W;
  localparam int PW    = W + 2;
  localparam int STEPS = W + 3;
  localparam int CW    = $clog2(STEPS);
  localparam logic [CW-1:0] LAST_Q = CW'(W);
  localparam logic [CW-1:0] CORR   = CW'(W + 1);

  logic            busy;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   op_a;
  logic [W-1:0]    op_b;
  div_mode_t       op_mode;
  logic [PW-1:0]   p_r;
  logic [W-1:0]    n_r;
  logic [W-1:0]    b_r;
  logic            qn_r, rn_r;

  logic [PW-1:0]   p_init, p_nxt;
  logic [W-1:0]    n_init, n_nxt, b_mag, q_fix, r_fix;
  logic            q_neg, r_neg;

  div_setup #(.W(W)) u_setup (
    .a(op_a), .b(op_b), .mode(op_mode),
    .p_init(p_init), .n_init(n_init), .b_mag(b_mag),
    .q_neg(q_neg), .r_neg(r_neg)
  );

  div_step #(.W(W)) u_step (
    .p_in(p_r), .n_in(n_r), .b(b_r), .p_out(p_nxt), .n_out(n_nxt)
  );

  div_fixup #(.W(W)) u_fix (
    .q_mag(n_r), .p_fin(p_r), .q_neg(qn_r), .r_neg(rn_r),
    .q_out(q_fix), .r_out(r_fix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      op_a      <= '0;
      op_b      <= '0;
      op_mode   <= '0;
      p_r       <= '0;
      n_r       <= '0;
      b_r       <= '0;
      qn_r      <= 1'b0;
      rn_r      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      done      <= 1'b0;
      div_zero  <= 1'b0;
    end else if (start && !busy) begin
      op_a         <= dividend;
      op_b         <= divisor;
      op_mode.wide <= wide;
      op_mode.sgn  <= sgn;
      op_mode.frac <= frac;
      busy         <= 1'b1;
      cnt          <= '0;
      done         <= 1'b0;
      div_zero     <= (divisor == '0);
    end else if (busy && step_en) begin
      cnt <= cnt + 1'b1;
      if (cnt == '0) begin
        p_r  <= p_init;
        n_r  <= n_init;
        b_r  <= b_mag;
        qn_r <= q_neg;
        rn_r <= r_neg;
      end else if (cnt <= LAST_Q) begin
        p_r <= p_nxt;
        n_r <= n_nxt;
      end else if (cnt == CORR) begin
        if (p_r[PW-1]) p_r <= p_r + {2'b00, b_r};
      end else begin
        quotient  <= q_fix;
        remainder <= r_fix;
        done      <= 1'b1;
        busy      <= 1'b0;
        cnt       <= '0;
      end
    end
  end
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int W = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         start,
  input logic                         step_en,
  input logic [W-1:0]                 divisor,
  input logic [W-1:0]                 quotient,
  input logic [W-1:0]                 remainder,
  input logic                         done,
  input logic                         div_zero,
  input logic                         busy,
  input logic [$clog2(W+3)-1:0]       cnt,
  input logic [W-1:0]                 op_b
);
  localparam int CW = $clog2(W + 3);
  localparam logic [CW-1:0] LAST = CW'(W + 2);

  p_start_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done));

  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= LAST));

  p_done_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(cnt) == LAST && $past(step_en) && $past(busy)));

  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !step_en) |=> ($stable(cnt) && busy && !done));

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (div_zero == ($past(divisor) == '0)));

  p_ignore_start_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(op_b));

  p_hold_out_r11: assert property (@(posedge clk) disable iff (rst)
    !(busy && step_en && cnt == LAST) |=> ($stable(quotient) && $stable(remainder)));
endmodule

bind iter_divider div_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .step_en(step_en), .divisor(divisor),
  .quotient(quotient), .remainder(remainder), .done(done), .div_zero(div_zero),
  .busy(busy), .cnt(cnt), .op_b(op_b)
);

// File: tb/tb_iter_divider.sv
module tb_iter_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, step_en = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        wide = 1'b0, sgn = 1'b0, frac = 1'b0;
  logic [15:0] quotient, remainder;
  logic        done, div_zero;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  iter_divider dut (
    .clk(clk), .rst(rst), .start(start), .step_en(step_en),
    .dividend(dividend), .divisor(divisor), .wide(wide), .sgn(sgn), .frac(frac),
    .quotient(quotient), .remainder(remainder), .done(done), .div_zero(div_zero)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void calc(input logic [31:0] a, input logic [15:0] b,
                               input bit w, input bit s, input bit f,
                               output logic [15:0] q, output logic [15:0] r);
    longint av, bv, qq, rr;
    if (f || !w) av = s ? longint'($signed(a[15:0])) : longint'(a[15:0]);
    else         av = s ? longint'($signed(a)) : longint'(a);
    if (f) av = av * 32768;
    bv = s ? longint'($signed(b)) : longint'(b);
    qq = av / bv;
    rr = av % bv;
    q = qq[15:0];
    r = rr[15:0];
  endfunction

  function automatic string mode_tag(input bit w, input bit s, input bit f);
    if (f) return "R8";
    if (s) return "R7";
    if (w) return "R6";
    return "R5";
  endfunction

  // behavioural reference: counts enabled steps, predicts flags and results
  bit          m_busy, m_done, m_dz, m_valid;
  int          m_cnt;
  logic [15:0] m_q, m_r, p_q, p_r;
  string       m_tag, p_tag;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_dz = 0; m_valid = 1; m_cnt = 0;
      m_q = '0; m_r = '0; m_tag = "R1";
    end else if (start && !m_busy) begin
      m_busy = 1; m_cnt = 0; m_done = 0; m_dz = (divisor == 16'h0);
      if (!m_dz) calc(dividend, divisor, wide, sgn, frac, p_q, p_r);
      p_tag = mode_tag(wide, sgn, frac);
    end else if (m_busy && step_en) begin
      m_cnt++;
      if (m_cnt == 19) begin
        m_busy = 0; m_done = 1; m_valid = !m_dz;
        m_q = p_q; m_r = p_r; m_tag = p_tag;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(done === m_done, "R3 done timing", done, m_done);
      check(div_zero === m_dz, "R9 div_zero", div_zero, m_dz);
      if (m_valid) begin
        check(quotient === m_q, m_done ? {m_tag, " quotient"} : "R11 quotient hold", quotient, m_q);
        check(remainder === m_r, m_done ? {m_tag, " remainder"} : "R11 remainder hold", remainder, m_r);
      end
    end
  end

  task automatic run_op(input logic [31:0] a, input logic [15:0] b, input bit w,
                        input bit s, input bit f, input int pause_pct, input bit poke);
    logic [15:0] eq, er;
    int i;
    @(negedge clk);
    dividend = a; divisor = b; wide = w; sgn = s; frac = f;
    start = 1'b1; step_en = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b0, "R2 done cleared by start", done, 0);
    for (i = 0; i < 2000 && !m_done; i++) begin
      step_en = ($urandom_range(99) >= pause_pct);
      if (poke && i == 3) begin
        start = 1'b1; dividend = ~a; divisor = b + 16'd3; sgn = ~s; frac = ~f;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; step_en = 1'b0;
    if (!m_done) check(1'b0, "R3 watchdog per op", 0, 1);
    if (b != 16'h0) begin
      calc(a, b, w, s, f, eq, er);
      if (poke) check(quotient === eq && remainder === er, "R10 start during run ignored",
                      {quotient, remainder}, {eq, er});
      if (pause_pct > 0) check(quotient === eq && remainder === er, "R4 paused run result",
                               {quotient, remainder}, {eq, er});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [15:0] b;
    int bm, qm, rm;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && div_zero === 1'b0, "R1 reset flags", {done, div_zero}, 0);
    check(quotient === 16'h0 && remainder === 16'h0, "R1 reset outputs", {quotient, remainder}, 0);
    rst = 1'b0;

    // directed corner cases
    run_op(32'h0000_FFFF, 16'h0001, 0, 0, 0, 0, 0);   // R5 max / 1
    run_op(32'h0000_0007, 16'hFFFF, 0, 0, 0, 0, 0);   // R5 small / large
    run_op(32'hFFFE_FFFF, 16'hFFFF, 1, 0, 0, 0, 0);   // R6 largest fitting quotient
    run_op(32'h0000_FFF9, 16'h0002, 0, 1, 0, 0, 0);   // R7 -7 / 2
    run_op(32'h0000_0007, 16'hFFFE, 0, 1, 0, 0, 0);   // R7 7 / -2
    run_op(32'hFFFE_7960, 16'h0007, 1, 1, 0, 0, 0);   // R7 -100000 / 7
    run_op(32'h0000_2000, 16'h4000, 0, 0, 1, 0, 0);   // R8 0.25 / 0.5
    run_op(32'h0000_E000, 16'h4000, 0, 1, 1, 0, 0);   // R8 -0.25 / 0.5
    run_op(32'h0000_1234, 16'h0000, 0, 0, 0, 0, 0);   // R9 zero divisor
    run_op(32'h0000_1234, 16'h0000, 1, 1, 0, 60, 0);  // R9 zero divisor, paused
    run_op(32'h0000_1234, 16'h0035, 0, 0, 0, 0, 0);   // R9 flag clears

    for (int k = 0; k < 160; k++) begin
      int sel = k % 5;
      int pct = (k % 4) * 25;
      bit pk = (k % 7 == 0);
      case (sel)
        0: begin
          a = {16'h0, 16'($urandom)};
          b = 16'($urandom_range(1, 65535));
          run_op(a, b, 0, 0, 0, pct, pk);
        end
        1: begin
          b = 16'($urandom_range(1, 65535));
          qm = $urandom_range(0, 65535);
          rm = $urandom_range(0, int'(b) - 1);
          a = 32'(qm) * 32'(b) + 32'(rm);
          run_op(a, b, 1, 0, 0, pct, pk);
        end
        2: begin
          a = {16'h0, 16'($urandom)};
          b = 16'($urandom_range(1, 65535));
          if (a[15:0] == 16'h8000 && b == 16'hFFFF) b = 16'h0001;
          run_op(a, b, 0, 1, 0, pct, pk);
        end
        3: begin
          bm = $urandom_range(1, 32767);
          qm = $urandom_range(0, 32767);
          rm = $urandom_range(0, bm - 1);
          a = 32'(qm) * 32'(bm) + 32'(rm);
          if ($urandom_range(1)) a = ~a + 1;
          b = 16'(bm);
          if ($urandom_range(1)) b = ~b + 1;
          run_op(a, b, 1, 1, 0, pct, pk);
        end
        default: begin
          bm = $urandom_range(1, 32767);
          rm = $urandom_range(0, bm - 1);
          if (k % 2 == 0) begin
            a = {16'h0, 16'(rm)}; b = 16'(bm);
            if ($urandom_range(1)) a[15:0] = ~a[15:0] + 1;
            if ($urandom_range(1)) b = ~b + 1;
            run_op(a, b, 0, 1, 1, pct, pk);
          end else begin
            b = 16'($urandom_range(1, 65535));
            a = {16'h0, 16'($urandom_range(0, int'(b) - 1))};
            run_op(a, b, 1, 0, 1, pct, pk);
          end
        end
      endcase
    end

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule